// File: doc/BRIEF.md
# Vector Instruction Fetch Sequencer

This block sits at the head of a vector display generator. It holds a vector program counter, reads the vector program one byte at a time from a byte-wide memory, and steers each byte into the field it belongs to. The fields are a 3-bit opcode for the decode stage, a 13-bit Y delta, a 13-bit X delta and a 3-bit intensity reference. Each instruction begins with the same opcode-capturing step. The opcode then selects whether two or four bytes make up the instruction.

A `start` pulse loads the counter from `start_pc` and begins fetching. After each instruction, `done` pulses for one clock. Fetching of the next instruction then continues unless `halt` is high, in which case the block returns to idle. Every byte takes two clocks. In the first, a read is requested. In the second, the returned byte is latched and the counter advances.

Top module: `vec_fetch_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_rd` and `done` are 0, and `opcode`, `dx`, `dy` and `zref` are all 0.
- R2: While `mem_rd` is 1, `mem_addr` equals 0x2000 plus the program counter, so program location 0 is byte 0x2000. The data is expected on `mem_rdata` in the clock that follows.
- R3: The first byte of every instruction sets `opcode` to its bits 7:5 and `dy[12:8]` to its bits 4:0.
- R4: The second byte of every instruction is written to `dy[7:0]`.
- R5: Opcode 000 marks a long instruction of four bytes. The third byte sets `zref` to bits 7:5 and `dx[12:8]` to bits 4:0. The fourth byte sets `dx[7:0]`.
- R6: Any other opcode marks a two-byte instruction. When its first byte is latched, `dx` and `zref` are cleared to 0.
- R7: `done` is high for exactly one clock after the last byte of an instruction is latched. In the next clock a read for the next instruction is issued, unless `halt` is 1.
- R8: The program counter rises by one for every byte latched. It carries through all 12 bits and wraps from 0xFFF to 0x000 only.
- R9: `start` has an effect only while idle. `halt` is looked at only in the `done` clock and has no effect in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin fetching from `start_pc` (used when idle) |
| halt | input | 1 | Stop after the current instruction |
| start_pc | input | 12 | Program location of the first instruction |
| mem_rd | output | 1 | Read request to vector memory |
| mem_addr | output | 16 | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid the clock after `mem_rd` |
| opcode | output | 3 | Opcode for the decode stage |
| dx | output | 13 | X delta |
| dy | output | 13 | Y delta |
| zref | output | 3 | Intensity reference |
| done | output | 1 | One-clock pulse: instruction assembled |
| busy | output | 1 | Fetching is in progress |

## Verification
Some properties are checked on every clock by assertions. `done` never lasts two clocks. A read clock is always followed by a clock with no read. Read addresses stay inside the window that starts at 0x2000. The counter advances by exactly one across each latch clock. When `done` is high for a two-byte instruction, the X fields are zero. Other behaviour can only be shown by the bench's scenarios, which compare every clock against a behavioural model: that each byte goes to the correct field, that the byte count follows the opcode, that the counter carries across 0x0FF and wraps at 0xFFF, that a `start` pulse while busy is ignored, and that `halt` takes effect only at an instruction boundary.

// File: rtl/vec_fetch_seq.sv
module vec_fetch_seq #(
  parameter int PC_W   = 12,
  parameter int BUS_W  = 16,
  parameter logic [BUS_W-1:0] BASE = 16'h2000,
  parameter logic [2:0] LONG_OP = 3'b000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             halt,
  input  logic [PC_W-1:0]  start_pc,
  output logic             mem_rd,
  output logic [BUS_W-1:0] mem_addr,
  input  logic [7:0]       mem_rdata,
  output logic [2:0]       opcode,
  output logic [12:0]      dx,
  output logic [12:0]      dy,
  output logic [2:0]       zref,
  output logic             done,
  output logic             busy
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_LT, S_DONE} state_t;

  state_t          state;
  logic [PC_W-1:0] pc;
  logic [1:0]      step;
  logic            is_long;
  logic [1:0]      lat;
  logic            long_now;
  logic            last;

  assign mem_rd   = (state == S_RD);
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_DONE);
  assign mem_addr = mem_rd ? BASE + {{(BUS_W-PC_W){1'b0}}, pc} : '0;

  assign long_now = (step == 2'd0) ? (mem_rdata[7:5] == LONG_OP) : is_long;

  always_comb begin
    case (step)
      2'd0:    lat = 2'd1;
      2'd1:    lat = 2'd0;
      2'd2:    lat = 2'd3;
      default: lat = 2'd2;
    endcase
  end

  assign last = long_now ? (step == 2'd3) : (step == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pc      <= '0;
      step    <= '0;
      is_long <= 1'b0;
      opcode  <= '0;
      dx      <= '0;
      dy      <= '0;
      zref    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_RD;
          pc    <= start_pc;
          step  <= '0;
        end
        S_RD: state <= S_LT;
        S_LT: begin
          case (lat)
            2'd1: begin
              opcode   <= mem_rdata[7:5];
              dy[12:8] <= mem_rdata[4:0];
              is_long  <= long_now;
              if (!long_now) begin
                dx   <= '0;
                zref <= '0;
              end
            end
            2'd0: dy[7:0] <= mem_rdata;
            2'd3: begin
              zref     <= mem_rdata[7:5];
              dx[12:8] <= mem_rdata[4:0];
            end
            default: dx[7:0] <= mem_rdata;
          endcase
          pc    <= pc + 1'b1;
          step  <= step + 1'b1;
          state <= last ? S_DONE : S_RD;
        end
        default: begin
          step  <= '0;
          state <= halt ? S_IDLE : S_RD;
        end
      endcase
    end
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !halt) |=> mem_rd);

  a_r2_rd_then_latch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  a_r2_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr >= BASE &&
                mem_addr <= BASE + {{(BUS_W-PC_W){1'b0}}, {PC_W{1'b1}}}));

  a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LT) |=> (pc == PC_W'($past(pc) + 1'b1)));

  a_r6_short_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done && opcode != LONG_OP) |-> (dx == '0 && zref == '0));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !done));

endmodule

// File: tb/vec_fetch_seq_tb.sv
module vec_fetch_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic halt = 1'b0;
  logic [11:0] start_pc = '0;
  logic mem_rd;
  logic [15:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic [2:0] opcode, zref;
  logic [12:0] dx, dy;
  logic done, busy;

  int total = 0;
  int bad = 0;

  logic [7:0] mem [0:4095];

  int m_st = 0;
  int m_step = 0;
  int m_len = 2;
  int m_pc = 0;
  int m_op = 0, m_dx = 0, m_dy = 0, m_z = 0;

  always #10 clk = ~clk;

  vec_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .start_pc(start_pc),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .opcode(opcode), .dx(dx), .dy(dy), .zref(zref), .done(done), .busy(busy)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_step = 0; m_pc = 0; m_op = 0; m_dx = 0; m_dy = 0; m_z = 0;
    end else begin
      case (m_st)
        0: if (start) begin m_st = 1; m_pc = int'(start_pc); m_step = 0; end
        1: m_st = 2;
        2: begin
          int b;
          b = int'(mem[m_pc]);
          if (m_step == 0) begin
            m_op = b / 32;
            m_dy = (m_dy % 256) + (b % 32) * 256;
            m_len = (m_op == 0) ? 4 : 2;
            if (m_op != 0) begin m_dx = 0; m_z = 0; end
          end else if (m_step == 1) m_dy = (m_dy / 256) * 256 + b;
          else if (m_step == 2) begin m_z = b / 32; m_dx = (m_dx % 256) + (b % 32) * 256; end
          else m_dx = (m_dx / 256) * 256 + b;
          m_pc = (m_pc + 1) % 4096;
          m_step = m_step + 1;
          m_st = (m_step == m_len) ? 3 : 1;
        end
        default: begin m_step = 0; m_st = halt ? 0 : 1; end
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(busy == (m_st != 0), "R9 busy", busy, m_st != 0);
    check(mem_rd == (m_st == 1), "R9 mem_rd", mem_rd, m_st == 1);
    if (m_st == 1) check(int'(mem_addr) == 32'h2000 + m_pc, "R2 R8 mem_addr", mem_addr, 32'h2000 + m_pc);
    check(done == (m_st == 3), "R7 done", done, m_st == 3);
    check(int'(opcode) == m_op, "R3 opcode", opcode, m_op);
    check(int'(dy[12:8]) == m_dy / 256, "R3 dy_hi", dy[12:8], m_dy / 256);
    check(int'(dy[7:0]) == m_dy % 256, "R4 dy_lo", dy[7:0], m_dy % 256);
    check(int'(dx) == m_dx, (m_op == 0) ? "R5 dx" : "R6 dx", dx, m_dx);
    check(int'(zref) == m_z, (m_op == 0) ? "R5 zref" : "R6 zref", zref, m_z);
  end

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic kick(input logic [11:0] pc, input bit h);
    start_pc = pc; halt = h; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 73 + 29) ^ (i >> 5));
    mem[12'h010] = 8'h15; mem[12'h011] = 8'h3C; mem[12'h012] = 8'hAA; mem[12'h013] = 8'hA5;
    mem[12'h014] = 8'h67; mem[12'h015] = 8'h5A;
    mem[12'h0FE] = 8'h1F; mem[12'h0FF] = 8'hFF; mem[12'h100] = 8'hFF; mem[12'h101] = 8'h80;
    mem[12'hFFE] = 8'h00; mem[12'hFFF] = 8'h01; mem[12'h000] = 8'h40; mem[12'h001] = 8'h02;

    repeat (3) @(negedge clk);
    check(!busy && !mem_rd && !done, "R1 idle outputs", {busy, mem_rd, done}, 0);
    check(dx == 0 && dy == 0 && opcode == 0 && zref == 0, "R1 fields", dx | dy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    kick(12'h010, 1'b1);
    wait_done();
    check(dy == 13'h153C, "R4 long dy", dy, 13'h153C);
    check(dx == 13'h0AA5 && zref == 3'd5, "R5 long dx zref", {zref, dx}, {3'd5, 13'h0AA5});
    @(negedge clk);
    check(!busy, "R7 halt at boundary", busy, 0);

    kick(12'h0FE, 1'b0);
    wait_done();
    check(dx == 13'h1F80 && dy == 13'h1FFF, "R8 carry past 0x0FF", dx, 13'h1F80);
    @(negedge clk);
    check(mem_rd && mem_addr == 16'h2102, "R7 resume next instr", mem_addr, 16'h2102);
    start_pc = 12'h555; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    check(busy, "R9 halt ignored mid-instruction", busy, 1);
    wait_idle();

    kick(12'hFFE, 1'b1);
    wait_done();
    check(dx == 13'h0002 && zref == 3'd2 && dy == 13'h0001, "R8 wrap 0xFFF", dx, 13'h0002);
    wait_idle();

    kick(12'h014, 1'b1);
    wait_done();
    check(opcode == 3'd3 && dy == 13'h075A, "R3 short opcode", dy, 13'h075A);
    check(dx == 0 && zref == 0, "R6 short clears X", dx, 0);
    wait_idle();
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule